// File: doc/BRIEF.md
# Event Counter with Alarm

This block counts rising edges on an external event line in a 24-bit binary register and raises a one-cycle interrupt pulse when the count steps onto a programmed alarm value. The event line is asynchronous: it is brought into the system clock domain by a two-flop synchronizer and edge-detected before it reaches the counter.

Software sees the block through three byte-wide locations at 8 (bits 7:0), 9 (bits 15:8) and 0xA (bits 23:16). A target-select input decides whether a write lands in the count or in the alarm. The alarm cannot be read back, so reads of these locations always return the count. Writing any count byte halts counting. Writing the low byte restarts it, so a full value can be loaded before the first event is taken. Reading the high byte freezes a copy of all three bytes for the reads that follow, so a carry between byte reads cannot tear the value. Reading the low byte releases that copy. The live counter keeps advancing while the copy is held.

Top module: `evcnt_alarm`

## Requirements
- R1: After reset the count is 0, counting is enabled, no snapshot is held, `irq_o` is low and `rd_data_o` is 0.
- R2: Each rising edge of `event_i` adds one to the count, provided the line stays high and then low for at least 3 clock cycles each. The count wraps from 0xFFFFFF to 0.
- R3: While `wr_wr_en_i` is high, the target is chosen by `alarm_sel_i`. A value of 1 writes the alarm byte and 0 writes the count byte. Address 8 holds bits 7:0, 9 holds bits 15:8 and 0xA holds bits 23:16.
- R4: A read of address 8, 9 or 0xA returns the count whatever the value of `alarm_sel_i`. An alarm write neither changes the count nor stops it.
- R5: A count write to 9 or 0xA stops counting, and events arriving while stopped are ignored. A count write to 8 loads the low byte and restarts counting.
- R6: A read of 0xA while no snapshot is held captures all three count bytes. Later reads of 9 and 8 return the captured bytes, and a read of 8 releases the snapshot.
- R7: The live count keeps advancing while a snapshot is held. A coherent read taken after the release returns the advanced value.
- R8: With no snapshot held, a read of 8 or 9 returns the live byte and captures nothing.
- R9: `irq_o` pulses high for exactly one cycle, in the cycle where an event has just moved the count to a value equal to the alarm. Loading the count with the alarm value by a write raises no pulse.
- R10: `rd_data_o` shows the read byte in the cycle after `rd_en_i` and keeps it until the next read. A read of any address other than 8, 9 or 0xA returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| event_i | input | 1 | Asynchronous event line; rising edges are counted |
| addr_i | input | 4 | Register address |
| wr_en_i | input | 1 | Write strobe, one cycle |
| wr_data_i | input | 8 | Write byte |
| alarm_sel_i | input | 1 | Write target: 1 alarm, 0 count |
| rd_en_i | input | 1 | Read strobe, one cycle |
| rd_data_o | output | 8 | Registered read byte |
| irq_o | output | 1 | One-cycle alarm match pulse |

## Verification
The bench loads the count one byte at a time and feeds events between the byte writes. A design that kept counting after a high or middle byte write would return a count that has drifted from the loaded value. It reads the high byte, sends events, then reads the middle and low bytes. A design without the snapshot would return torn bytes, and one that froze the live counter would lose the events on the later coherent read. Around the alarm it checks that exactly one pulse appears when events step onto the alarm value. It also checks that a wrap onto an alarm of zero fires, and that writing the alarm value into the count fires nothing. A design that compared the alarm on every cycle would fire repeatedly or on the write. Reads with the alarm target selected must still return the count.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  typedef enum logic {
    TGT_COUNT = 1'b0,
    TGT_ALARM = 1'b1
  } wr_tgt_e;
endpackage

// File: rtl/evcnt_sync_edge.sv
module evcnt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R2: the edge pulse never lasts two cycles
  a_r2_single_rise: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/evcnt_core.sv
module evcnt_core #(
  parameter int CNT_W  = 24,
  parameter int BYTE_W = 8,
  localparam int NBYTES = CNT_W / BYTE_W,
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc_i,
  input  logic              cnt_wr_i,
  input  logic              alm_wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nx, alm_q, alm_nx, cnt_plus;
  logic             run_q, step;

  assign step     = inc_i && run_q && !cnt_wr_i;
  assign cnt_plus = cnt_q + CNT_W'(1);

  always_comb begin
    cnt_nx = cnt_q;
    alm_nx = alm_q;
    for (int b = 0; b < NBYTES; b++) begin
      if (idx_i == IDX_W'(b)) begin
        if (cnt_wr_i) cnt_nx[b*BYTE_W +: BYTE_W] = data_i;
        if (alm_wr_i) alm_nx[b*BYTE_W +: BYTE_W] = data_i;
      end
    end
    if (step) cnt_nx = cnt_plus;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      alm_q <= '0;
      run_q <= 1'b1;
      irq_o <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      alm_q <= alm_nx;
      if (cnt_wr_i) run_q <= (idx_i == '0);
      irq_o <= step && (cnt_plus == alm_q);
    end
  end

  assign cnt_o = cnt_q;

  // R2: a counted event adds exactly one, wrapping at the top
  a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
    (inc_i && run_q && !cnt_wr_i) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  // R5: a stopped counter with no write holds its value
  a_r5_halt_holds: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !cnt_wr_i) |=> $stable(cnt_q));
  // R4: an alarm write without an event leaves the count alone
  a_r4_alarm_keeps_count: assert property (@(posedge clk) disable iff (rst)
    (alm_wr_i && !cnt_wr_i && !inc_i) |=> $stable(cnt_q));
  // R9: a pulse means an event moved the count onto the alarm
  a_r9_irq_on_match: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(inc_i) && cnt_q == $past(alm_q)));
endmodule

// File: rtl/evcnt_rdlatch.sv
module evcnt_rdlatch #(
  parameter int CNT_W  = 24,
  parameter int BYTE_W = 8,
  localparam int NBYTES = CNT_W / BYTE_W,
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  logic [CNT_W-1:0]  snap_q, src;
  logic              held_q;
  logic [BYTE_W-1:0] sel_byte;

  assign src = held_q ? snap_q : cnt_i;

  always_comb begin
    sel_byte = '0;
    for (int b = 0; b < NBYTES; b++)
      if (idx_i == IDX_W'(b)) sel_byte = src[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q    <= '0;
      held_q    <= 1'b0;
      rd_data_o <= '0;
    end else if (rd_i) begin
      if (hit_i) begin
        rd_data_o <= sel_byte;
        if (idx_i == IDX_W'(NBYTES-1) && !held_q) begin
          snap_q <= cnt_i;
          held_q <= 1'b1;
        end
        if (idx_i == '0) held_q <= 1'b0;
      end else begin
        rd_data_o <= '0;
      end
    end
  end

  // R6: the snapshot stays put until the low byte is read
  a_r6_snap_frozen: assert property (@(posedge clk) disable iff (rst)
    (held_q && !(rd_i && hit_i && idx_i == '0)) |=> ($stable(snap_q) && held_q));
  // R10: the read byte holds between reads
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rd_data_o));
endmodule

// File: rtl/evcnt_alarm.sv
module evcnt_alarm #(
  parameter int CNT_W     = 24,
  parameter int BYTE_W    = 8,
  parameter int ADDR_W    = 4,
  parameter int BASE_ADDR = 8,
  parameter int SYNC_STG  = 2,
  localparam int NBYTES   = CNT_W / BYTE_W,
  localparam int IDX_W    = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              event_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              alarm_sel_i,
  input  logic              rd_en_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              irq_o
);
  import evcnt_pkg::*;

  logic             hit, rise, cnt_wr, alm_wr;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt;
  wr_tgt_e          tgt;
  logic [ADDR_W:0]  offs;

  assign offs   = {1'b0, addr_i} - (ADDR_W+1)'(BASE_ADDR);
  assign hit    = (int'(addr_i) >= BASE_ADDR) && (int'(addr_i) < BASE_ADDR + NBYTES);
  assign idx    = offs[IDX_W-1:0];
  assign tgt    = wr_tgt_e'(alarm_sel_i);
  assign cnt_wr = wr_en_i && hit && (tgt == TGT_COUNT);
  assign alm_wr = wr_en_i && hit && (tgt == TGT_ALARM);

  evcnt_sync_edge #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .async_i(event_i), .rise_o(rise)
  );

  evcnt_core #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_core (
    .clk(clk), .rst(rst), .inc_i(rise), .cnt_wr_i(cnt_wr), .alm_wr_i(alm_wr),
    .idx_i(idx), .data_i(wr_data_i), .cnt_o(cnt), .irq_o(irq_o)
  );

  evcnt_rdlatch #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_rd (
    .clk(clk), .rst(rst), .rd_i(rd_en_i), .hit_i(hit), .idx_i(idx),
    .cnt_i(cnt), .rd_data_o(rd_data_o)
  );

  // R9: interrupt is a single-cycle pulse
  a_r9_irq_pulse: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);
  // R10: an unmapped read returns zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !hit) |=> rd_data_o == '0);
endmodule

// File: tb/test_evcnt_alarm.sv
`timescale 1ns/1ps
module test_evcnt_alarm;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       event_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       alarm_sel_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       irq_o;

  int checks = 0;
  int failures = 0;
  int irq_count = 0;

  always #2.5 clk = ~clk;

  evcnt_alarm i_evcnt_alarm (
    .clk(clk), .rst(rst), .event_i(event_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .alarm_sel_i(alarm_sel_i),
    .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  always @(negedge clk) if (!rst && irq_o) irq_count++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse_events(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) event_i = 1'b1;
      repeat (4) @(negedge clk);
      event_i = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic sel);
    @(negedge clk);
    addr_i = a; wr_data_i = d; alarm_sel_i = sel; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
    d = rd_data_o;
  endtask

  task automatic rd_count(output int v);
    logic [7:0] h, m, l;
    rd(4'hA, h); rd(4'h9, m); rd(4'h8, l);
    v = {8'h0, h, m, l};
  endtask

  task automatic t_reset;
    int v;
    check("R1 rd_data", int'(rd_data_o), 0);
    check("R1 irq", int'(irq_o), 0);
    rd_count(v);
    check("R1 count", v, 0);
  endtask

  task automatic t_count;
    int v;
    pulse_events(5);
    rd_count(v);
    check("R2 five events", v, 5);
  endtask

  task automatic t_wrap;
    int v, base;
    wr(4'hA, 8'hFF, 1'b0); wr(4'h9, 8'hFF, 1'b0); wr(4'h8, 8'hFE, 1'b0);
    rd_count(v);
    check("R3 count load", v, 32'hFFFFFE);
    base = irq_count;
    pulse_events(2);
    rd_count(v);
    check("R2 wrap to zero", v, 0);
    check("R9 wrap onto zero alarm", irq_count - base, 1);
  endtask

  task automatic t_halt;
    int v;
    wr(4'h9, 8'h12, 1'b0);
    pulse_events(3);
    rd_count(v);
    check("R5 halted after mid write", v, 32'h001200);
    wr(4'h8, 8'h34, 1'b0);
    pulse_events(1);
    rd_count(v);
    check("R5 resume after low write", v, 32'h001235);
  endtask

  task automatic t_alarm;
    int v, base;
    wr(4'h8, 8'h37, 1'b1); wr(4'h9, 8'h12, 1'b1); wr(4'hA, 8'h00, 1'b1);
    alarm_sel_i = 1'b1;
    rd_count(v);
    check("R4 read with alarm target", v, 32'h001235);
    base = irq_count;
    pulse_events(1);
    check("R9 no pulse before match", irq_count - base, 0);
    pulse_events(1);
    check("R9 one pulse on match", irq_count - base, 1);
    pulse_events(1);
    check("R9 no pulse after match", irq_count - base, 1);
    rd_count(v);
    check("R4 count kept running", v, 32'h001238);
    alarm_sel_i = 1'b0;
    base = irq_count;
    wr(4'hA, 8'h00, 1'b0); wr(4'h9, 8'h12, 1'b0); wr(4'h8, 8'h37, 1'b0);
    repeat (4) @(negedge clk);
    check("R9 no pulse on count write", irq_count - base, 0);
  endtask

  task automatic t_latch;
    logic [7:0] d;
    int v;
    rd(4'hA, d);
    check("R6 high byte", int'(d), 0);
    pulse_events(3);
    rd(4'h9, d);
    check("R6 mid from snapshot", int'(d), 8'h12);
    rd(4'h8, d);
    check("R6 low from snapshot", int'(d), 8'h37);
    rd_count(v);
    check("R7 live count advanced", v, 32'h00123A);
  endtask

  task automatic t_single;
    logic [7:0] d;
    rd(4'h8, d);
    check("R8 live low", int'(d), 8'h3A);
    pulse_events(1);
    rd(4'h8, d);
    check("R8 low not frozen", int'(d), 8'h3B);
    rd(4'h9, d);
    check("R8 live mid", int'(d), 8'h12);
  endtask

  task automatic t_readpath;
    logic [7:0] d;
    rd(4'h3, d);
    check("R10 unmapped 3", int'(d), 0);
    rd(4'hB, d);
    check("R10 unmapped B", int'(d), 0);
    rd(4'h8, d);
    pulse_events(2);
    check("R10 read data held", int'(rd_data_o), 8'h3B);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_count();
    t_wrap();
    t_halt();
    t_alarm();
    t_latch();
    t_single();
    t_readpath();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule